// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

This block keeps speculative instructions in program order between issue and retirement. It holds eight entries in a circular buffer. The issue stage reserves an entry and receives that entry's index as a tag. Execution units return their results over a shared result bus addressed by that tag, and results may arrive in any order. The oldest entry retires only after its result has arrived. Retiring an ordinary entry writes the register file. A store retires by writing memory, so its memory update waits until retirement. A branch found to be mispredicted discards every entry and sends the correct PC back to fetch.

A register-to-entry map records which entry will produce each architectural register. It feeds two operand lookup ports. Through them the issue stage learns whether a source register is waiting on an entry, which entry that is, and whether its value is already present in the buffer. Reservation stations and execution units lie outside the block. A free reservation station is reported on one input line.

Top module: `rob_top`

## Requirements
- R1: `alloc_ready` is high exactly when `rs_free` is high, fewer than 8 entries are held and `flush` is low. An accepted request (`alloc_valid` and `alloc_ready`) returns `alloc_tag` in the same cycle. Tags are handed out in order starting at 0 and wrap from 7 back to 0. The codes for `alloc_kind` are 0 for a register-writing operation, 1 for a store and 2 for a branch.
- R2: The buffer holds at most 8 entries. While it is full, `alloc_ready` stays low even with `rs_free` high, and a request made while `alloc_ready` is low changes no entry.
- R3: A result-bus write (`cdb_valid`) to a held entry stores `cdb_value`, `cdb_addr` and `cdb_mispred` and marks the entry done. Writes may arrive in any order. A write to a tag that holds no entry is ignored.
- R4: Entries retire strictly in allocation order, at most one per cycle, and only when the oldest entry is done. A retiring register-writing entry drives `rf_we`=1, `rf_addr`=its destination and `rf_data`=its value in the cycle after its result write.
- R5: A retiring store drives `mem_we`=1, `mem_addr`=its `cdb_addr` and `mem_data`=its `cdb_value`, and never drives `rf_we`. `mem_we` stays low before the store retires.
- R6: A retiring branch with `cdb_mispred`=0 drives none of `rf_we`, `mem_we` or `flush`. A retiring branch with `cdb_mispred`=1 drives `flush`=1 and `flush_pc`=its `cdb_addr` for one cycle. That discards every younger entry, and the next allocation returns tag 0.
- R7: For each lookup port s, `src_pending[s]` is high when register `src_reg[s]` has a producing entry, and `src_tag[s]` names that entry. `src_ready[s]` is high when that entry is done, and `src_value[s]` then carries its value.
- R8: When an entry retires, the map for its destination is cleared only if it still names that entry. A younger producer of the same register stays visible.
- R9: A flush clears the whole register-to-entry map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rs_free | input | 1 | A reservation station is available |
| alloc_valid | input | 1 | Issue stage requests an entry |
| alloc_kind | input | 2 | 0 register op, 1 store, 2 branch |
| alloc_dest | input | 5 | Destination register of a register op |
| alloc_ready | output | 1 | Request can be accepted this cycle |
| alloc_tag | output | 3 | Index of the entry being reserved |
| cdb_valid | input | 1 | Result bus write |
| cdb_tag | input | 3 | Entry addressed by the result |
| cdb_value | input | 32 | Result value or store data |
| cdb_addr | input | 32 | Store address or branch target |
| cdb_mispred | input | 1 | Branch was mispredicted |
| src_reg | input | 10 | Two lookup register indices, port s at bits [5s+4:5s] |
| src_pending | output | 2 | Register has a producing entry |
| src_ready | output | 2 | Producing entry already has its value |
| src_tag | output | 6 | Producing entry per port |
| src_value | output | 64 | Buffered value per port |
| rf_we | output | 1 | Register file write at retirement |
| rf_addr | output | 5 | Register written |
| rf_data | output | 32 | Value written |
| mem_we | output | 1 | Memory write at store retirement |
| mem_addr | output | 32 | Store address |
| mem_data | output | 32 | Store data |
| flush | output | 1 | Mispredicted branch retires, discard all state |
| flush_pc | output | 32 | Correct fetch PC |

## Verification
`alloc_ready` and `alloc_tag` follow the inputs within the same cycle. A result write takes effect at the next edge, so the lookup ports and the retirement outputs (`rf_we`, `mem_we`, `flush`) show it one cycle after the write. After each further edge the next entry in order retires. The cycle after `flush` shows an empty buffer with a cleared map. The bench drives inputs just after the falling edge. It reads outputs one nanosecond later, before the next rising edge, and counts edges from each stimulus to decide in which cycle every check belongs.

// File: rtl/rob_pkg.sv
package rob_pkg;
    localparam int ROB_DEPTH = 8;
    localparam int TAG_W     = $clog2(ROB_DEPTH);
    localparam int CNT_W     = $clog2(ROB_DEPTH + 1);
    localparam int NUM_REGS  = 32;
    localparam int REG_W     = $clog2(NUM_REGS);
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 32;
    localparam int NUM_SRC   = 2;

    typedef enum logic [1:0] {
        KIND_REG    = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_BRANCH = 2'd2
    } kind_e;

    // addr holds the store address for stores and the target for branches
    typedef struct packed {
        logic              busy;
        kind_e             kind;
        logic [REG_W-1:0]  dest;
        logic [DATA_W-1:0] value;
        logic              done;
        logic [ADDR_W-1:0] addr;
        logic              mispred;
    } slot_t;

    function automatic logic [TAG_W-1:0] ptr_inc(input logic [TAG_W-1:0] p);
        return (p == TAG_W'(ROB_DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs
    import rob_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic             clear,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    assign full  = (count == CNT_W'(ROB_DEPTH));
    assign empty = (count == '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= ptr_inc(tail);
            if (pop)  head <= ptr_inc(head);
            count <= count + {{(CNT_W-1){1'b0}}, push} - {{(CNT_W-1){1'b0}}, pop};
        end
    end

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(ROB_DEPTH));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
endmodule

// File: rtl/rob_regmap.sv
module rob_regmap
    import rob_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_reg,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_reg,
    input  logic [TAG_W-1:0] clr_tag,
    output logic [NUM_REGS-1:0] map_valid,
    output logic [TAG_W-1:0] map_tag [NUM_REGS]
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                map_valid[g] <= 1'b0;
                map_tag[g]   <= '0;
            end else if (set_en && set_reg == REG_W'(g)) begin
                map_valid[g] <= 1'b1;
                map_tag[g]   <= set_tag;
            end else if (clr_en && clr_reg == REG_W'(g) && map_tag[g] == clr_tag) begin
                map_valid[g] <= 1'b0;
            end
        end
    end

    // R9
    map_flush_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (map_valid == '0));

    // R8
    map_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !clear && !set_en && map_tag[clr_reg] != clr_tag)
        |=> map_valid[$past(clr_reg)] == $past(map_valid[clr_reg]));
endmodule

// File: rtl/rob_lookup.sv
module rob_lookup
    import rob_pkg::*;
(
    input  logic [REG_W-1:0]    reg_idx,
    input  logic [NUM_REGS-1:0] map_valid,
    input  logic [TAG_W-1:0]    map_tag [NUM_REGS],
    input  logic [ROB_DEPTH-1:0] done_vec,
    input  logic [DATA_W-1:0]   val_arr [ROB_DEPTH],
    output logic                pending,
    output logic                ready,
    output logic [TAG_W-1:0]    tag,
    output logic [DATA_W-1:0]   value
);
    always_comb begin
        pending = map_valid[reg_idx];
        tag     = map_tag[reg_idx];
        ready   = pending && done_vec[tag];
        value   = val_arr[tag];
    end
endmodule

// File: rtl/rob_top.sv
module rob_top
    import rob_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rs_free,
    input  logic                      alloc_valid,
    input  logic [1:0]                alloc_kind,
    input  logic [REG_W-1:0]          alloc_dest,
    output logic                      alloc_ready,
    output logic [TAG_W-1:0]          alloc_tag,
    input  logic                      cdb_valid,
    input  logic [TAG_W-1:0]          cdb_tag,
    input  logic [DATA_W-1:0]         cdb_value,
    input  logic [ADDR_W-1:0]         cdb_addr,
    input  logic                      cdb_mispred,
    input  logic [NUM_SRC*REG_W-1:0]  src_reg,
    output logic [NUM_SRC-1:0]        src_pending,
    output logic [NUM_SRC-1:0]        src_ready,
    output logic [NUM_SRC*TAG_W-1:0]  src_tag,
    output logic [NUM_SRC*DATA_W-1:0] src_value,
    output logic                      rf_we,
    output logic [REG_W-1:0]          rf_addr,
    output logic [DATA_W-1:0]         rf_data,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [DATA_W-1:0]         mem_data,
    output logic                      flush,
    output logic [ADDR_W-1:0]         flush_pc
);
    slot_t             slots [ROB_DEPTH];
    slot_t             hd;
    logic [TAG_W-1:0]  head, tail;
    logic [CNT_W-1:0]  count;
    logic              full, empty;
    logic              alloc_fire, retire;
    kind_e             new_kind;
    logic [ROB_DEPTH-1:0] done_vec;
    logic [DATA_W-1:0] val_arr [ROB_DEPTH];
    logic [NUM_REGS-1:0] map_valid;
    logic [TAG_W-1:0]  map_tag [NUM_REGS];

    assign new_kind    = kind_e'(alloc_kind);
    assign hd          = slots[head];
    assign retire      = hd.busy && hd.done;
    assign flush       = retire && hd.kind == KIND_BRANCH && hd.mispred;
    assign flush_pc    = hd.addr;
    assign rf_we       = retire && hd.kind == KIND_REG;
    assign rf_addr     = hd.dest;
    assign rf_data     = hd.value;
    assign mem_we      = retire && hd.kind == KIND_STORE;
    assign mem_addr    = hd.addr;
    assign mem_data    = hd.value;
    assign alloc_ready = rs_free && !full && !flush;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign alloc_tag   = tail;

    rob_ptrs u_ptrs (
        .clk(clk), .rst(rst), .push(alloc_fire), .pop(retire), .clear(flush),
        .head(head), .tail(tail), .count(count), .full(full), .empty(empty)
    );

    rob_regmap u_map (
        .clk(clk), .rst(rst), .clear(flush),
        .set_en(alloc_fire && new_kind == KIND_REG), .set_reg(alloc_dest), .set_tag(tail),
        .clr_en(rf_we), .clr_reg(hd.dest), .clr_tag(head),
        .map_valid(map_valid), .map_tag(map_tag)
    );

    for (genvar g = 0; g < ROB_DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                slots[g] <= '0;
            end else if (alloc_fire && tail == TAG_W'(g)) begin
                slots[g].busy    <= 1'b1;
                slots[g].kind    <= new_kind;
                slots[g].dest    <= alloc_dest;
                slots[g].value   <= '0;
                slots[g].done    <= 1'b0;
                slots[g].addr    <= '0;
                slots[g].mispred <= 1'b0;
            end else begin
                if (cdb_valid && cdb_tag == TAG_W'(g) && slots[g].busy) begin
                    slots[g].value   <= cdb_value;
                    slots[g].addr    <= cdb_addr;
                    slots[g].mispred <= cdb_mispred;
                    slots[g].done    <= 1'b1;
                end
                if (retire && head == TAG_W'(g)) slots[g].busy <= 1'b0;
            end
        end
        assign done_vec[g] = slots[g].done;
        assign val_arr[g]  = slots[g].value;
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        rob_lookup u_lk (
            .reg_idx(src_reg[s*REG_W +: REG_W]),
            .map_valid(map_valid), .map_tag(map_tag),
            .done_vec(done_vec), .val_arr(val_arr),
            .pending(src_pending[s]), .ready(src_ready[s]),
            .tag(src_tag[s*TAG_W +: TAG_W]), .value(src_value[s*DATA_W +: DATA_W])
        );
    end

    // R3
    done_set_chk: assert property (@(posedge clk) disable iff (rst)
        (cdb_valid && slots[cdb_tag].busy && !flush) |=> slots[$past(cdb_tag)].done);

    // R6
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (empty && !rf_we && !mem_we));

    // R1
    tag_seq_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_fire |=> alloc_tag == ptr_inc($past(alloc_tag)));

    // R4
    head_step_chk: assert property (@(posedge clk) disable iff (rst)
        (retire && !flush) |=> head == ptr_inc($past(head)));

    // R5
    store_no_rf_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !rf_we);
endmodule

// File: tb/rob_top_bench.sv
`timescale 1ns/1ps
module rob_top_bench;
    import rob_pkg::*;

    logic clk = 1'b0;
    logic rst;
    logic rs_free, alloc_valid, cdb_valid, cdb_mispred;
    logic [1:0] alloc_kind;
    logic [REG_W-1:0] alloc_dest;
    logic alloc_ready;
    logic [TAG_W-1:0] alloc_tag, cdb_tag;
    logic [DATA_W-1:0] cdb_value;
    logic [ADDR_W-1:0] cdb_addr;
    logic [NUM_SRC*REG_W-1:0] src_reg;
    logic [NUM_SRC-1:0] src_pending, src_ready;
    logic [NUM_SRC*TAG_W-1:0] src_tag;
    logic [NUM_SRC*DATA_W-1:0] src_value;
    logic rf_we, mem_we, flush;
    logic [REG_W-1:0] rf_addr;
    logic [DATA_W-1:0] rf_data, mem_data;
    logic [ADDR_W-1:0] mem_addr, flush_pc;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    rob_top u_rob_top (
        .clk(clk), .rst(rst), .rs_free(rs_free), .alloc_valid(alloc_valid),
        .alloc_kind(alloc_kind), .alloc_dest(alloc_dest), .alloc_ready(alloc_ready),
        .alloc_tag(alloc_tag), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
        .cdb_value(cdb_value), .cdb_addr(cdb_addr), .cdb_mispred(cdb_mispred),
        .src_reg(src_reg), .src_pending(src_pending), .src_ready(src_ready),
        .src_tag(src_tag), .src_value(src_value), .rf_we(rf_we), .rf_addr(rf_addr),
        .rf_data(rf_data), .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .flush(flush), .flush_pc(flush_pc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic quiet();
        alloc_valid = 1'b0; alloc_kind = 2'd0; alloc_dest = '0; rs_free = 1'b1;
        cdb_valid = 1'b0; cdb_tag = '0; cdb_value = '0; cdb_addr = '0; cdb_mispred = 1'b0;
    endtask

    // one cycle: inputs cleared after falling edge, outputs readable on return
    task automatic idle();
        @(negedge clk);
        quiet();
        #1;
    endtask

    task automatic alloc(input logic [1:0] kind, input logic [4:0] dest,
                         input logic [2:0] exp_tag, input string req);
        @(negedge clk);
        quiet();
        alloc_valid = 1'b1; alloc_kind = kind; alloc_dest = dest;
        #1;
        chk({req, " ready"}, {31'd0, alloc_ready}, 32'd1);
        chk({req, " tag"}, {29'd0, alloc_tag}, {29'd0, exp_tag});
    endtask

    task automatic result(input logic [2:0] tag, input logic [31:0] val,
                          input logic [31:0] addr, input logic mis);
        @(negedge clk);
        quiet();
        cdb_valid = 1'b1; cdb_tag = tag; cdb_value = val; cdb_addr = addr; cdb_mispred = mis;
        #1;
    endtask

    task automatic look(input logic [4:0] r0, input logic [4:0] r1);
        src_reg = {r1, r0};
        #0.1;
    endtask

    task automatic t_reset();
        idle();
        chk("R1 reset ready", {31'd0, alloc_ready}, 32'd1);
        chk("R1 reset tag", {29'd0, alloc_tag}, 32'd0);
        chk("R4 reset rf_we", {31'd0, rf_we}, 32'd0);
        chk("R5 reset mem_we", {31'd0, mem_we}, 32'd0);
        chk("R6 reset flush", {31'd0, flush}, 32'd0);
        look(5'd3, 5'd4);
        chk("R7 reset pending", {30'd0, src_pending}, 32'd0);
    endtask

    task automatic t_out_of_order();
        alloc(2'd0, 5'd3, 3'd0, "R1 alloc A");
        alloc(2'd0, 5'd4, 3'd1, "R1 alloc B");
        result(3'd1, 32'h44, 32'h0, 1'b0);
        idle();
        chk("R4 younger done, no retire", {31'd0, rf_we}, 32'd0);
        look(5'd3, 5'd4);
        chk("R7 reg3 pending", {31'd0, src_pending[0]}, 32'd1);
        chk("R7 reg3 not ready", {31'd0, src_ready[0]}, 32'd0);
        chk("R7 reg3 tag", {29'd0, src_tag[2:0]}, 32'd0);
        chk("R3 R7 reg4 ready", {31'd0, src_ready[1]}, 32'd1);
        chk("R7 reg4 tag", {29'd0, src_tag[5:3]}, 32'd1);
        chk("R7 reg4 value", src_value[63:32], 32'h44);
        result(3'd0, 32'h33, 32'h0, 1'b0);
        idle();
        chk("R4 first retire we", {31'd0, rf_we}, 32'd1);
        chk("R4 first retire addr", {27'd0, rf_addr}, 32'd3);
        chk("R4 first retire data", rf_data, 32'h33);
        idle();
        chk("R4 second retire we", {31'd0, rf_we}, 32'd1);
        chk("R4 second retire addr", {27'd0, rf_addr}, 32'd4);
        chk("R4 second retire data", rf_data, 32'h44);
        idle();
        chk("R4 drained", {31'd0, rf_we}, 32'd0);
        look(5'd3, 5'd4);
        chk("R8 map cleared on retire", {30'd0, src_pending}, 32'd0);
    endtask

    task automatic t_store();
        alloc(2'd1, 5'd0, 3'd2, "R1 alloc store");
        idle();
        chk("R5 no early memory write", {31'd0, mem_we}, 32'd0);
        look(5'd0, 5'd0);
        chk("R7 store maps no register", {30'd0, src_pending}, 32'd0);
        result(3'd2, 32'hDEAD, 32'h100, 1'b0);
        idle();
        chk("R5 store mem_we", {31'd0, mem_we}, 32'd1);
        chk("R5 store addr", mem_addr, 32'h100);
        chk("R5 store data", mem_data, 32'hDEAD);
        chk("R5 store no rf_we", {31'd0, rf_we}, 32'd0);
        idle();
        chk("R5 single memory write", {31'd0, mem_we}, 32'd0);
    endtask

    task automatic t_full();
        @(negedge clk);
        quiet();
        rs_free = 1'b0; alloc_valid = 1'b1;
        #1;
        chk("R1 no reservation station", {31'd0, alloc_ready}, 32'd0);
        for (int i = 0; i < 8; i++)
            alloc(2'd0, 5'(8 + i), 3'((3 + i) % 8), "R1 fill wrap");
        @(negedge clk);
        quiet();
        alloc_valid = 1'b1; alloc_dest = 5'd30;
        #1;
        chk("R2 full blocks", {31'd0, alloc_ready}, 32'd0);
        for (int i = 7; i >= 0; i--)
            result(3'((3 + i) % 8), 32'h100 + 32'(i), 32'h0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            idle();
            chk("R4 R2 in-order retire we", {31'd0, rf_we}, 32'd1);
            chk("R4 R2 in-order retire addr", {27'd0, rf_addr}, 32'(8 + i));
            chk("R4 R2 in-order retire data", rf_data, 32'h100 + 32'(i));
        end
        idle();
        chk("R2 drained ready", {31'd0, alloc_ready}, 32'd1);
        chk("R2 drained tag", {29'd0, alloc_tag}, 32'd3);
        chk("R4 nothing left", {31'd0, rf_we}, 32'd0);
    endtask

    task automatic t_same_dest();
        alloc(2'd0, 5'd9, 3'd3, "R1 alloc X");
        alloc(2'd0, 5'd9, 3'd4, "R1 alloc Y");
        result(3'd3, 32'h91, 32'h0, 1'b0);
        idle();
        chk("R4 older retires", rf_data, 32'h91);
        idle();
        look(5'd9, 5'd9);
        chk("R8 younger still pending", {31'd0, src_pending[0]}, 32'd1);
        chk("R8 younger tag", {29'd0, src_tag[2:0]}, 32'd4);
        chk("R8 younger not ready", {31'd0, src_ready[0]}, 32'd0);
        result(3'd4, 32'h92, 32'h0, 1'b0);
        idle();
        chk("R4 younger retires", rf_data, 32'h92);
        idle();
        look(5'd9, 5'd9);
        chk("R8 cleared after last producer", {31'd0, src_pending[0]}, 32'd0);
    endtask

    task automatic t_branch_ok();
        alloc(2'd2, 5'd0, 3'd5, "R1 alloc branch");
        result(3'd5, 32'h0, 32'h3000, 1'b0);
        idle();
        chk("R6 predicted branch no flush", {31'd0, flush}, 32'd0);
        chk("R6 predicted branch no rf", {31'd0, rf_we}, 32'd0);
        chk("R6 predicted branch no mem", {31'd0, mem_we}, 32'd0);
        idle();
        chk("R6 branch retired", {29'd0, alloc_tag}, 32'd6);
    endtask

    task automatic t_mispredict();
        alloc(2'd2, 5'd0, 3'd6, "R1 alloc branch");
        alloc(2'd0, 5'd5, 3'd7, "R1 alloc younger op");
        alloc(2'd1, 5'd0, 3'd0, "R1 alloc younger store");
        result(3'd7, 32'h55, 32'h0, 1'b0);
        result(3'd0, 32'h66, 32'h200, 1'b0);
        result(3'd6, 32'h0, 32'h2000, 1'b1);
        idle();
        chk("R6 flush", {31'd0, flush}, 32'd1);
        chk("R6 flush pc", flush_pc, 32'h2000);
        chk("R6 no rf write at flush", {31'd0, rf_we}, 32'd0);
        chk("R1 no alloc during flush", {31'd0, alloc_ready}, 32'd0);
        idle();
        chk("R6 flush one cycle", {31'd0, flush}, 32'd0);
        chk("R6 younger op discarded", {31'd0, rf_we}, 32'd0);
        chk("R6 younger store discarded", {31'd0, mem_we}, 32'd0);
        chk("R6 tag restarts", {29'd0, alloc_tag}, 32'd0);
        look(5'd5, 5'd9);
        chk("R9 map cleared", {30'd0, src_pending}, 32'd0);
        idle();
        chk("R6 still nothing retires", {30'd0, {rf_we, mem_we}}, 32'd0);
    endtask

    task automatic t_stray_write();
        result(3'd3, 32'h77, 32'h0, 1'b0);
        idle();
        chk("R3 write to empty slot ignored", {30'd0, {rf_we, mem_we}}, 32'd0);
        alloc(2'd0, 5'd6, 3'd0, "R1 alloc after flush");
        idle();
        look(5'd6, 5'd6);
        chk("R7 new producer pending", {31'd0, src_pending[0]}, 32'd1);
        chk("R7 new producer not ready", {31'd0, src_ready[0]}, 32'd0);
        chk("R4 not done, no retire", {31'd0, rf_we}, 32'd0);
        result(3'd0, 32'h60, 32'h0, 1'b0);
        idle();
        chk("R4 retire after flush", {31'd0, rf_we}, 32'd1);
        chk("R4 retire after flush addr", {27'd0, rf_addr}, 32'd6);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        quiet();
        src_reg = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_out_of_order();
        t_store();
        t_full();
        t_same_dest();
        t_branch_ok();
        t_mispredict();
        t_stray_write();
        idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule